// File: doc/BRIEF.md
# Real-Time-Clock Register Port

This block is the host-facing register window of a real-time clock. The host reaches a 128-byte register space through two addresses. A write to the even address selects a byte. An access to the odd address reads or writes the selected byte. Most bytes are plain storage. Four control bytes at indices 10 to 13 carry side effects: a status bit the host cannot write, a set mode that freezes the time, a read-to-clear interrupt status byte that drives the interrupt line, and a fixed valid byte.

A separate timekeeping block does the calendar arithmetic. This port tells it when the time bytes must be reloaded into its counters, through a load strobe. It tells it when the data format has changed and the bytes must be rewritten, through a reformat strobe. The timekeeper drives the update-in-progress bit and reports update, alarm and periodic events. It writes the time bytes back through its own write port and reads them through a read port.

Top module: `rtc_regport`

## Requirements
- R1: A host write to address 0 stores bits 6:0 of the data as the index, and bit 7 is dropped. A host read of address 0 returns 0xFF.
- R2: Bytes with no side effect (the alarm bytes 1, 3 and 5, and indices 14 to 127) return on an odd-address read what was last written to them. Writing them raises no strobe.
- R3: Bit 7 of byte 10 (update in progress) is kept when the host writes byte 10, and bits 6:0 take the written value. The timekeeper's set input sets the bit only while set mode (byte 11 bit 7) is low. Its clear input clears the bit.
- R4: A write to byte 11 with bit 7 (set mode) high stores bit 4 (update interrupt enable) as 0 and clears the update-in-progress bit.
- R5: A write to byte 11 with bit 7 low, made while bit 7 was high, pulses time_load in that write cycle.
- R6: A write to a time byte (indices 0, 2, 4, 6, 7, 8, 9) stores the value. It pulses time_load in that cycle only if set mode is low.
- R7: A write to byte 11 that changes bit 2 (binary mode) or bit 1 (24-hour mode), with bit 7 low in the new value, pulses reformat in that cycle.
- R8: An update event sets bit 4 of byte 12. An alarm event sets bit 5, and a periodic event sets bit 6, but only while byte 11 bit 5 or bit 6 respectively is high. Any event whose byte 11 enable (bit 4, 5 or 6) is high also sets bit 7 of byte 12. The irq output follows bit 7 of byte 12.
- R9: A read of byte 12 returns its value and clears it, so irq is low from the next cycle. An event in the same cycle as the read survives the clear.
- R10: Host writes to byte 12 and byte 13 have no effect.
- R11: A cold reset sets byte 10 to 0x26, byte 11 to 0x02, byte 12 to 0x00, and byte 13 reads 0x80.
- R12: A warm reset clears bits 6, 5 and 3 of byte 11 and bits 7 to 4 of byte 12. Every other bit is kept.
- R13: The timekeeper write port updates the addressed byte. When it hits the same byte as a host write in the same cycle, the host value wins. The timekeeper read port returns the stored byte.
- R14: time_load and reformat are high only during a host odd-address write cycle, and only for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous power-up reset |
| warm_rst | input | 1 | Synchronous later reset that clears enables and flags |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (a read of byte 12 clears it) |
| host_addr | input | 1 | 0 selects the index, 1 selects the data byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the read cycle |
| irq | output | 1 | Interrupt line, level |
| time_load | output | 1 | Pulse: timekeeper must reload the time from the bytes |
| reformat | output | 1 | Pulse: timekeeper must rewrite the bytes in the new format |
| mode_a | output | 8 | Current byte 10, for the divider and rate logic |
| mode_b | output | 8 | Current byte 11, for the timekeeper |
| tk_uip_set | input | 1 | Timekeeper: update starting |
| tk_uip_clr | input | 1 | Timekeeper: update finished |
| tk_evt_update | input | 1 | Timekeeper: update-ended event |
| tk_evt_alarm | input | 1 | Timekeeper: alarm match event |
| tk_evt_periodic | input | 1 | Timekeeper: periodic tick event |
| tk_we | input | 1 | Timekeeper byte write enable |
| tk_idx | input | 7 | Timekeeper write index |
| tk_wdata | input | 8 | Timekeeper write data |
| tk_rd_idx | input | 7 | Timekeeper read index |
| tk_rd_data | output | 8 | Timekeeper read data |

## Verification
Embedded assertions check the following on every cycle:
- The index capture.
- That an update-enable bit is never stored while set mode is high, and that update-in-progress stays low in set mode.
- That the status byte is empty after an uncontended read.
- That byte 12 ignores host writes.
- That irq only rises with an enable present.
- That the strobes never appear outside a host data write.

Only the scenarios can show the exact strobe decisions for each sequence of byte 11 writes, the warm-reset bit masks, the priority of an event over a same-cycle clear, and the host-over-timekeeper write priority. Each of these needs a chosen history of register values before the result can be predicted.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;

    localparam int DATA_W = 8;

    // register indices whose behaviour other logic decodes
    localparam int IX_SEC   = 0;
    localparam int IX_MIN   = 2;
    localparam int IX_HOUR  = 4;
    localparam int IX_WDAY  = 6;
    localparam int IX_MDAY  = 7;
    localparam int IX_MON   = 8;
    localparam int IX_YEAR  = 9;
    localparam int IX_CTLA  = 10;
    localparam int IX_CTLB  = 11;
    localparam int IX_STAT  = 12;
    localparam int IX_VALID = 13;

    // bit positions
    localparam int A_BUSY   = 7;
    localparam int B_FREEZE = 7;
    localparam int B_PER_EN = 6;
    localparam int B_ALM_EN = 5;
    localparam int B_UPD_EN = 4;
    localparam int B_SQW_EN = 3;
    localparam int B_BIN    = 2;
    localparam int B_H24    = 1;
    localparam int C_ANY    = 7;
    localparam int C_PER    = 6;
    localparam int C_ALM    = 5;
    localparam int C_UPD    = 4;

    localparam logic [DATA_W-1:0] CTLA_INIT  = 8'h26;
    localparam logic [DATA_W-1:0] CTLB_INIT  = 8'h02;
    localparam logic [DATA_W-1:0] STAT_INIT  = 8'h00;
    localparam logic [DATA_W-1:0] VALID_BYTE = 8'h80;
    localparam logic [DATA_W-1:0] IDX_READ   = 8'hFF;

    localparam logic [DATA_W-1:0] CTLB_WARM_KEEP =
        ~((8'(1) << B_PER_EN) | (8'(1) << B_ALM_EN) | (8'(1) << B_SQW_EN));
    localparam logic [DATA_W-1:0] STAT_WARM_KEEP =
        ~((8'(1) << C_ANY) | (8'(1) << C_PER) | (8'(1) << C_ALM) | (8'(1) << C_UPD));

    typedef enum logic [2:0] {
        TGT_PLAIN,
        TGT_TIME,
        TGT_CTLA,
        TGT_CTLB,
        TGT_STAT,
        TGT_VALID
    } tgt_e;

    typedef struct packed {
        logic data_wr;
        logic data_rd;
        tgt_e tgt;
    } acc_t;

    typedef struct packed {
        logic load;
        logic reformat;
    } strobe_t;

    typedef struct packed {
        logic update;
        logic alarm;
        logic periodic;
    } evt_t;

    function automatic tgt_e classify(input int unsigned ix);
        case (ix)
            IX_SEC, IX_MIN, IX_HOUR, IX_WDAY,
            IX_MDAY, IX_MON, IX_YEAR: classify = TGT_TIME;
            IX_CTLA:                  classify = TGT_CTLA;
            IX_CTLB:                  classify = TGT_CTLB;
            IX_STAT:                  classify = TGT_STAT;
            IX_VALID:                 classify = TGT_VALID;
            default:                  classify = TGT_PLAIN;
        endcase
    endfunction

endpackage

// File: rtl/rtc_index_dec.sv
module rtc_index_dec
    import rtc_regport_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [IDX_W-1:0]  idx,
    output acc_t              acc
);

    logic idx_wr;

    assign idx_wr = host_wr && !host_addr;

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            idx <= '0;
        end else if (idx_wr) begin
            idx <= host_wdata[IDX_W-1:0];
        end
    end

    always_comb begin
        acc.data_wr = host_wr && host_addr;
        acc.data_rd = host_rd && !host_wr && host_addr;
        acc.tgt     = classify(int'(idx));
    end

    AST_INDEX_CAPTURE: assert property (@(posedge clk) disable iff (cold_rst) (host_wr && !host_addr) |=> (idx == $past(host_wdata[IDX_W-1:0]))); // R1

endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
    import rtc_regport_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [DATA_W-1:0] host_data,
    input  logic              tk_we,
    input  logic [IDX_W-1:0]  tk_idx,
    input  logic [DATA_W-1:0] tk_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_b
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // the host write is issued last so it wins a same-index collision
    always_ff @(posedge clk) begin
        if (tk_we) begin
            mem[tk_idx] <= tk_data;
        end
        if (host_we) begin
            mem[host_idx] <= host_data;
        end
    end

    assign rd_data_a = mem[rd_idx_a];
    assign rd_data_b = mem[rd_idx_b];

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_regport_pkg::*;
(
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              warm_rst,
    input  acc_t              acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              uip_set,
    input  logic              uip_clr,
    input  evt_t              evt,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic [DATA_W-1:0] reg_c,
    output strobe_t           strb,
    output logic              irq
);

    logic              wr_a, wr_b, wr_c, wr_time, rd_c, any_rst;
    logic [DATA_W-1:0] a_nxt, b_nxt, c_nxt;

    assign any_rst = cold_rst || warm_rst;
    assign wr_a    = acc.data_wr && (acc.tgt == TGT_CTLA);
    assign wr_b    = acc.data_wr && (acc.tgt == TGT_CTLB);
    assign wr_c    = acc.data_wr && (acc.tgt == TGT_STAT);
    assign wr_time = acc.data_wr && (acc.tgt == TGT_TIME);
    assign rd_c    = acc.data_rd && (acc.tgt == TGT_STAT);

    always_comb begin
        a_nxt = reg_a;
        b_nxt = reg_b;
        c_nxt = reg_c;
        strb  = '0;

        // control A: busy bit is owned by the timekeeper
        if (wr_a) begin
            a_nxt[A_BUSY-1:0] = wdata[A_BUSY-1:0];
        end

        // control B: set mode, enables, format
        if (wr_b) begin
            b_nxt = wdata;
            if (wdata[B_FREEZE]) begin
                b_nxt[B_UPD_EN] = 1'b0;
            end else if (reg_b[B_FREEZE]) begin
                strb.load = 1'b1;
            end
            if (!wdata[B_FREEZE] &&
                ((reg_b[B_BIN] != wdata[B_BIN]) || (reg_b[B_H24] != wdata[B_H24]))) begin
                strb.reformat = 1'b1;
            end
        end

        if (wr_time && !reg_b[B_FREEZE]) begin
            strb.load = 1'b1;
        end

        // busy bit: entering set mode beats the timekeeper inputs
        if (wr_b && wdata[B_FREEZE]) begin
            a_nxt[A_BUSY] = 1'b0;
        end else if (uip_clr) begin
            a_nxt[A_BUSY] = 1'b0;
        end else if (uip_set && !reg_b[B_FREEZE]) begin
            a_nxt[A_BUSY] = 1'b1;
        end

        // status: clear on read, then events
        if (rd_c) begin
            c_nxt = '0;
        end
        if (evt.update) begin
            c_nxt[C_UPD] = 1'b1;
            if (reg_b[B_UPD_EN]) begin
                c_nxt[C_ANY] = 1'b1;
            end
        end
        if (evt.alarm && reg_b[B_ALM_EN]) begin
            c_nxt[C_ALM] = 1'b1;
            c_nxt[C_ANY] = 1'b1;
        end
        if (evt.periodic && reg_b[B_PER_EN]) begin
            c_nxt[C_PER] = 1'b1;
            c_nxt[C_ANY] = 1'b1;
        end

        if (any_rst) begin
            strb = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            reg_a <= CTLA_INIT;
            reg_b <= CTLB_INIT;
            reg_c <= STAT_INIT;
        end else if (warm_rst) begin
            reg_b <= reg_b & CTLB_WARM_KEEP;
            reg_c <= reg_c & STAT_WARM_KEEP;
        end else begin
            reg_a <= a_nxt;
            reg_b <= b_nxt;
            reg_c <= c_nxt;
        end
    end

    assign irq = reg_c[C_ANY];

    AST_BUSY_HELD_ON_A_WRITE: assert property (@(posedge clk) disable iff (any_rst) (wr_a && !uip_set && !uip_clr) |=> (reg_a[A_BUSY] == $past(reg_a[A_BUSY]))); // R3
    AST_FREEZE_MASKS_UPD_EN: assert property (@(posedge clk) disable iff (any_rst) reg_b[B_FREEZE] |-> !reg_b[B_UPD_EN]); // R4
    AST_FREEZE_HOLDS_BUSY_LOW: assert property (@(posedge clk) disable iff (any_rst) reg_b[B_FREEZE] |-> !reg_a[A_BUSY]); // R4
    AST_STAT_EMPTY_AFTER_READ: assert property (@(posedge clk) disable iff (any_rst) (rd_c && !evt.update && !evt.alarm && !evt.periodic) |=> (reg_c == '0)); // R9
    AST_STAT_IGNORES_WRITE: assert property (@(posedge clk) disable iff (any_rst) (wr_c && !evt.update && !evt.alarm && !evt.periodic) |=> (reg_c == $past(reg_c))); // R10
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (any_rst) $rose(irq) |-> ($past(reg_b[B_UPD_EN]) || $past(reg_b[B_ALM_EN]) || $past(reg_b[B_PER_EN]))); // R8
    AST_STROBE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (any_rst) (strb.load || strb.reformat) |-> acc.data_wr); // R14

endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
    import rtc_regport_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              warm_rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq,
    output logic              time_load,
    output logic              reformat,
    output logic [DATA_W-1:0] mode_a,
    output logic [DATA_W-1:0] mode_b,
    input  logic              tk_uip_set,
    input  logic              tk_uip_clr,
    input  logic              tk_evt_update,
    input  logic              tk_evt_alarm,
    input  logic              tk_evt_periodic,
    input  logic              tk_we,
    input  logic [IDX_W-1:0]  tk_idx,
    input  logic [DATA_W-1:0] tk_wdata,
    input  logic [IDX_W-1:0]  tk_rd_idx,
    output logic [DATA_W-1:0] tk_rd_data
);

    logic [IDX_W-1:0]  idx;
    acc_t              acc;
    evt_t              evt;
    strobe_t           strb;
    logic [DATA_W-1:0] reg_a, reg_b, reg_c, store_rd;
    logic              store_we;

    rtc_index_dec #(.IDX_W(IDX_W)) u_idx (
        .clk        (clk),
        .cold_rst   (cold_rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .idx        (idx),
        .acc        (acc)
    );

    assign store_we = acc.data_wr && ((acc.tgt == TGT_TIME) || (acc.tgt == TGT_PLAIN));

    rtc_byte_store #(.IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .host_we   (store_we),
        .host_idx  (idx),
        .host_data (host_wdata),
        .tk_we     (tk_we),
        .tk_idx    (tk_idx),
        .tk_data   (tk_wdata),
        .rd_idx_a  (idx),
        .rd_data_a (store_rd),
        .rd_idx_b  (tk_rd_idx),
        .rd_data_b (tk_rd_data)
    );

    assign evt.update   = tk_evt_update;
    assign evt.alarm    = tk_evt_alarm;
    assign evt.periodic = tk_evt_periodic;

    rtc_ctrl_regs u_ctrl (
        .clk      (clk),
        .cold_rst (cold_rst),
        .warm_rst (warm_rst),
        .acc      (acc),
        .wdata    (host_wdata),
        .uip_set  (tk_uip_set),
        .uip_clr  (tk_uip_clr),
        .evt      (evt),
        .reg_a    (reg_a),
        .reg_b    (reg_b),
        .reg_c    (reg_c),
        .strb     (strb),
        .irq      (irq)
    );

    always_comb begin
        if (!host_addr) begin
            host_rdata = IDX_READ;
        end else begin
            case (acc.tgt)
                TGT_CTLA:  host_rdata = reg_a;
                TGT_CTLB:  host_rdata = reg_b;
                TGT_STAT:  host_rdata = reg_c;
                TGT_VALID: host_rdata = VALID_BYTE;
                default:   host_rdata = store_rd;
            endcase
        end
    end

    assign time_load = strb.load;
    assign reformat  = strb.reformat;
    assign mode_a    = reg_a;
    assign mode_b    = reg_b;

endmodule

// File: tb/rtc_regport_test.sv
module rtc_regport_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 33;

    logic       clk = 1'b0;
    logic       cold_rst = 1'b1;
    logic       warm_rst = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_addr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq, time_load, reformat;
    logic [7:0] mode_a, mode_b;
    logic       tk_uip_set = 1'b0, tk_uip_clr = 1'b0;
    logic       tk_evt_update = 1'b0, tk_evt_alarm = 1'b0, tk_evt_periodic = 1'b0;
    logic       tk_we = 1'b0;
    logic [6:0] tk_idx = '0;
    logic [7:0] tk_wdata = '0;
    logic [6:0] tk_rd_idx = '0;
    logic [7:0] tk_rd_data;

    int checks = 0;
    int errors = 0;
    logic ld_s, rf_s;
    logic [7:0] rd_s;

    rtc_regport uut (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .time_load(time_load), .reformat(reformat), .mode_a(mode_a), .mode_b(mode_b),
        .tk_uip_set(tk_uip_set), .tk_uip_clr(tk_uip_clr),
        .tk_evt_update(tk_evt_update), .tk_evt_alarm(tk_evt_alarm),
        .tk_evt_periodic(tk_evt_periodic), .tk_we(tk_we), .tk_idx(tk_idx),
        .tk_wdata(tk_wdata), .tk_rd_idx(tk_rd_idx), .tk_rd_data(tk_rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {is_read, addr, data, expected read, expected load, expected reformat, req}
    localparam logic [23:0] VECS [0:NVEC-1] = '{
        {1'b0, 1'b0, 8'h8E, 8'h00, 1'b0, 1'b0, 4'd1},   // R1 index 0x0E, bit 7 dropped
        {1'b0, 1'b1, 8'h5A, 8'h00, 1'b0, 1'b0, 4'd2},   // R2
        {1'b1, 1'b1, 8'h00, 8'h5A, 1'b0, 1'b0, 4'd2},   // R2
        {1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd1},   // R1
        {1'b0, 1'b0, 8'h01, 8'h00, 1'b0, 1'b0, 4'd2},   // R2 alarm byte
        {1'b0, 1'b1, 8'h33, 8'h00, 1'b0, 1'b0, 4'd2},   // R2 no strobe
        {1'b1, 1'b1, 8'h00, 8'h33, 1'b0, 1'b0, 4'd2},   // R2
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd6},   // R6 seconds
        {1'b0, 1'b1, 8'h45, 8'h00, 1'b1, 1'b0, 4'd6},   // R6 load outside set mode
        {1'b1, 1'b1, 8'h00, 8'h45, 1'b0, 1'b0, 4'd6},   // R6
        {1'b0, 1'b0, 8'h0B, 8'h00, 1'b0, 1'b0, 4'd7},   // R7
        {1'b0, 1'b1, 8'h06, 8'h00, 1'b0, 1'b1, 4'd7},   // R7 binary mode change
        {1'b1, 1'b1, 8'h00, 8'h06, 1'b0, 1'b0, 4'd7},   // R7
        {1'b0, 1'b1, 8'h96, 8'h00, 1'b0, 1'b0, 4'd4},   // R4 set mode with update enable
        {1'b1, 1'b1, 8'h00, 8'h86, 1'b0, 1'b0, 4'd4},   // R4 enable stored as 0
        {1'b0, 1'b0, 8'h09, 8'h00, 1'b0, 1'b0, 4'd6},   // R6 year
        {1'b0, 1'b1, 8'h24, 8'h00, 1'b0, 1'b0, 4'd6},   // R6 no load in set mode
        {1'b1, 1'b1, 8'h00, 8'h24, 1'b0, 1'b0, 4'd6},   // R6
        {1'b0, 1'b0, 8'h0B, 8'h00, 1'b0, 1'b0, 4'd5},   // R5
        {1'b0, 1'b1, 8'h04, 8'h00, 1'b1, 1'b1, 4'd5},   // R5 leave set mode, 24h changes
        {1'b1, 1'b1, 8'h00, 8'h04, 1'b0, 1'b0, 4'd5},   // R5
        {1'b0, 1'b0, 8'h0A, 8'h00, 1'b0, 1'b0, 4'd3},   // R3
        {1'b0, 1'b1, 8'hA5, 8'h00, 1'b0, 1'b0, 4'd3},   // R3 busy bit not writable
        {1'b1, 1'b1, 8'h00, 8'h25, 1'b0, 1'b0, 4'd3},   // R3
        {1'b0, 1'b0, 8'h0D, 8'h00, 1'b0, 1'b0, 4'd10},  // R10
        {1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 4'd10},  // R10
        {1'b1, 1'b1, 8'h00, 8'h80, 1'b0, 1'b0, 4'd10},  // R10
        {1'b0, 1'b0, 8'h0C, 8'h00, 1'b0, 1'b0, 4'd10},  // R10
        {1'b0, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b0, 4'd10},  // R10
        {1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 4'd10},  // R10
        {1'b0, 1'b0, 8'h0B, 8'h00, 1'b0, 1'b0, 4'd7},   // R7
        {1'b0, 1'b1, 8'h02, 8'h00, 1'b0, 1'b1, 4'd7},   // R7 both format bits change
        {1'b1, 1'b1, 8'h00, 8'h02, 1'b0, 1'b0, 4'd7}    // R7
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // tasks are entered at a falling edge and leave at the next one
    task automatic hwrite(input logic a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        #1 ld_s = time_load; rf_s = reformat;
        @(negedge clk);
        host_wr = 1'b0;
        #1 if (time_load !== 1'b0 || reformat !== 1'b0) begin
            checks++; errors++;
            $display("FAIL R14: strobe after write cycle actual=%b%b expected=00", time_load, reformat);
        end
    endtask

    task automatic hread(input logic a);
        host_rd = 1'b1; host_addr = a;
        #1 rd_s = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rd_byte(input logic [6:0] ix, input string tag, input logic [7:0] exp);
        hwrite(1'b0, {1'b0, ix});
        hread(1'b1);
        chk(tag, rd_s, exp);
    endtask

    task automatic wr_byte(input logic [6:0] ix, input logic [7:0] d);
        hwrite(1'b0, {1'b0, ix});
        hwrite(1'b1, d);
    endtask

    task automatic event_pulse(input logic u, input logic al, input logic p);
        tk_evt_update = u; tk_evt_alarm = al; tk_evt_periodic = p;
        @(negedge clk);
        tk_evt_update = 1'b0; tk_evt_alarm = 1'b0; tk_evt_periodic = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cold_rst = 1'b0;
        @(negedge clk);

        // R11 cold reset values
        rd_byte(7'd10, "R11 ctrl A", 8'h26);
        rd_byte(7'd11, "R11 ctrl B", 8'h02);
        rd_byte(7'd12, "R11 status", 8'h00);
        rd_byte(7'd13, "R11 valid", 8'h80);
        chk("R11 irq", {7'b0, irq}, 8'h00);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [23:0] v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d vec %0d", v[3:0], i);
            if (v[23]) begin
                hread(v[22]);
                chk(tag, rd_s, v[13:6]);
            end else begin
                hwrite(v[22], v[21:14]);
                chk({tag, " strobes"}, {6'b0, ld_s, rf_s}, {6'b0, v[5], v[4]});
            end
        end

        // R3 busy bit driven by the timekeeper
        tk_uip_set = 1'b1; @(negedge clk); tk_uip_set = 1'b0;
        rd_byte(7'd10, "R3 busy set", 8'hA5);
        wr_byte(7'd10, 8'h26);
        rd_byte(7'd10, "R3 busy kept over write", 8'hA6);
        tk_uip_clr = 1'b1; @(negedge clk); tk_uip_clr = 1'b0;
        rd_byte(7'd10, "R3 busy cleared", 8'h26);
        wr_byte(7'd11, 8'h82);
        tk_uip_set = 1'b1; @(negedge clk); tk_uip_set = 1'b0;
        rd_byte(7'd10, "R3 busy ignored in set mode", 8'h26);
        hwrite(1'b0, 8'h0B);
        hwrite(1'b1, 8'h02);
        chk("R5 leave set mode load", {7'b0, ld_s}, 8'h01);
        tk_uip_set = 1'b1; @(negedge clk); tk_uip_set = 1'b0;
        rd_byte(7'd10, "R3 busy set again", 8'hA6);
        wr_byte(7'd11, 8'h82);
        rd_byte(7'd10, "R4 set mode clears busy", 8'h26);
        wr_byte(7'd11, 8'h02);

        // R8 / R9 events and status read
        event_pulse(1'b1, 1'b0, 1'b0);
        chk("R8 update no enable irq", {7'b0, irq}, 8'h00);
        rd_byte(7'd12, "R8 update flag", 8'h10);
        rd_byte(7'd12, "R9 cleared by read", 8'h00);
        wr_byte(7'd11, 8'h12);
        event_pulse(1'b1, 1'b0, 1'b0);
        chk("R8 update enabled irq", {7'b0, irq}, 8'h01);
        rd_byte(7'd12, "R8 update with irq flag", 8'h90);
        chk("R9 irq low after read", {7'b0, irq}, 8'h00);
        event_pulse(1'b0, 1'b1, 1'b1);
        rd_byte(7'd12, "R8 alarm and periodic masked", 8'h00);
        wr_byte(7'd11, 8'h22);
        event_pulse(1'b0, 1'b1, 1'b0);
        rd_byte(7'd12, "R8 alarm enabled", 8'hA0);
        wr_byte(7'd11, 8'h42);
        event_pulse(1'b0, 1'b0, 1'b1);
        rd_byte(7'd12, "R8 periodic enabled", 8'hC0);

        // R9 event in the same cycle as the clearing read
        wr_byte(7'd11, 8'h12);
        event_pulse(1'b1, 1'b0, 1'b0);
        hwrite(1'b0, 8'h0C);
        tk_evt_update = 1'b1;
        hread(1'b1);
        tk_evt_update = 1'b0;
        chk("R9 read returns old value", rd_s, 8'h90);
        chk("R9 event survives clear irq", {7'b0, irq}, 8'h01);
        hread(1'b1);
        chk("R9 event survives clear value", rd_s, 8'h90);

        // R12 warm reset
        wr_byte(7'd11, 8'h7E);
        event_pulse(1'b1, 1'b0, 1'b0);
        chk("R12 irq before warm reset", {7'b0, irq}, 8'h01);
        warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
        chk("R12 irq after warm reset", {7'b0, irq}, 8'h00);
        rd_byte(7'd11, "R12 ctrl B masked", 8'h16);
        rd_byte(7'd12, "R12 status cleared", 8'h00);
        rd_byte(7'd10, "R12 ctrl A kept", 8'h26);

        // R13 timekeeper port, R14 no strobe from it
        wr_byte(7'd11, 8'h02);
        tk_we = 1'b1; tk_idx = 7'h20; tk_wdata = 8'h77;
        @(negedge clk); tk_we = 1'b0;
        rd_byte(7'h20, "R13 tk write", 8'h77);
        tk_we = 1'b1; tk_idx = 7'h20; tk_wdata = 8'h22;
        hwrite(1'b1, 8'h11);
        tk_we = 1'b0;
        rd_byte(7'h20, "R13 host wins collision", 8'h11);
        tk_rd_idx = 7'h20;
        #1 chk("R13 tk read port", tk_rd_data, 8'h11);
        hwrite(1'b0, 8'h00);
        tk_we = 1'b1; tk_idx = 7'h00; tk_wdata = 8'h59;
        host_rd = 1'b1; host_addr = 1'b1;
        #1 chk("R14 no strobe on read or tk write", {6'b0, time_load, reformat}, 8'h00);
        @(negedge clk);
        tk_we = 1'b0; host_rd = 1'b0;
        rd_byte(7'h00, "R13 tk write to time byte", 8'h59);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule